// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Register Unit

This block holds the configuration state of a pseudo-SRAM. It keeps a bus configuration register (operating mode, latency code, wait-signal polarity, output drive strength) and a refresh configuration register (partial-array refresh coverage, deep power-down control, page-mode enable). It also answers reads of a fixed, read-only identification word. The array itself and the pin-level timing belong to neighbouring blocks. This unit sees decoded bus cycles and updates or returns register contents.

The registers can be reached in two ways. On the pin path, the register-enable input is high during the cycle, and two address bits pick the register. On the software path, plain array cycles to the highest address form an unlock sequence: two reads, then a write whose data word names the register, then one final access that writes or reads that register. Any cycle that does not continue the sequence drops it without side effects.

Bus cycles arrive on a valid/ready request channel. Register reads are returned on a valid/ready response channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a register-read response waits, so there is at most one response outstanding. A response holds its data unchanged until `rsp_ready` accepts it. Array cycles that are not register accesses produce no response.

Top module: `psram_cfg_unit`

## Requirements
- R1: After reset the bus register reads 16'h9C10 and the refresh register reads 16'h0010. The bus register default is: bit 15 = 1 (asynchronous mode), bits 13:11 = 3'b011 (latency code 3), bit 10 = 1 (wait active high), bits 5:4 = 2'b01 (half drive). The refresh register default is: bit 4 = 1 (deep power-down off), bit 7 = 0 (page mode off), bits 2:0 = 0 (full array refresh).
- R2: A write with `req_cre` high updates a register selected by address bits [SEL_LSB+1:SEL_LSB]. Code 2'b00 selects the refresh register and 2'b10 selects the bus register. A write with code 2'b01 or 2'b11 changes nothing.
- R3: A read with `req_cre` high returns a response in the cycle after acceptance. Code 2'b00 returns the refresh register, 2'b10 the bus register, 2'b01 the identification word `DEV_ID`, and 2'b11 returns zero.
- R4: Only bus bits 15, 13:10 and 5:4, and refresh bits 7, 4 and 2:0, are writable. All other bits read zero and ignore writes.
- R5: A bus-register write whose latency field (bits 13:11) is a reserved code (0, 1 or 7) leaves the latency field unchanged and updates the other writable fields.
- R6: Software path, with `req_cre` low and address all ones: read, read, then a write whose data selects the target. Data 16'h0000 selects the refresh register, 16'h0001 the bus register and 16'h0002 the identification word. The next all-ones write then writes the target (ignored for the identification word), or the next all-ones read returns it as a response.
- R7: Any cycle that breaks the sequence sends it back to idle and changes no register. Breaking cycles are: any other address, any `req_cre` cycle, a write before two reads, a third read, selector data other than 0 to 2, or a non-final cycle after selection.
- R8: `req_ready` is low while a response is pending. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is high.
- R9: Array cycles that are not register accesses produce no response and leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus cycle present |
| req_ready | output | 1 | Unit can take a bus cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cre | input | 1 | Register-enable pin level for this cycle |
| req_addr | input | ADDR_W | Word address of the cycle |
| req_wdata | input | 16 | Write data of the cycle |
| rsp_valid | output | 1 | Register read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 16 | Register read data |
| bcr_q | output | 16 | Current bus configuration register |
| rcr_q | output | 16 | Current refresh configuration register |

## Verification
On every cycle, the assertions check four things: reserved bits stay zero, the latency field never holds a reserved code, registers move only on an accepted write, and the response channel holds and stalls new requests as specified. The bench scenarios are needed to show which register the two decode paths reach. They also show that each kind of broken unlock sequence leaves the registers untouched, that the reserved-latency merge keeps the old code, and that array cycles produce no response.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

  localparam int unsigned CFG_W   = 16;
  localparam int unsigned LAT_LSB = 11;
  localparam int unsigned LAT_W   = 3;

  localparam logic [CFG_W-1:0] BCR_WMASK = 16'hBC30;
  localparam logic [CFG_W-1:0] BCR_RST   = 16'h9C10;
  localparam logic [CFG_W-1:0] RCR_WMASK = 16'h0097;
  localparam logic [CFG_W-1:0] RCR_RST   = 16'h0010;
  localparam logic [CFG_W-1:0] LAT_MASK  = CFG_W'(((1 << LAT_W) - 1) << LAT_LSB);

  typedef enum logic [1:0] {
    TGT_RCR  = 2'd0,
    TGT_BCR  = 2'd1,
    TGT_DID  = 2'd2,
    TGT_NONE = 2'd3
  } cfg_tgt_e;

  function automatic logic lat_reserved(input logic [LAT_W-1:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd7);
  endfunction

  function automatic cfg_tgt_e pin_decode(input logic [1:0] sel, input logic is_write);
    cfg_tgt_e t;
    case (sel)
      2'b00:   t = TGT_RCR;
      2'b10:   t = TGT_BCR;
      2'b01:   t = is_write ? TGT_NONE : TGT_DID;
      default: t = TGT_NONE;
    endcase
    return t;
  endfunction

  function automatic cfg_tgt_e data_decode(input logic [CFG_W-1:0] d);
    cfg_tgt_e t;
    case (d)
      16'h0000: t = TGT_RCR;
      16'h0001: t = TGT_BCR;
      16'h0002: t = TGT_DID;
      default:  t = TGT_NONE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/psram_cfg_unlock.sv
module psram_cfg_unlock
  import psram_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_write,
  input  logic              acc_cre,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CFG_W-1:0]  acc_data,
  output logic              sw_hit,
  output cfg_tgt_e          sw_tgt
);

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2, S_ARM} seq_e;

  seq_e     state_q, state_d;
  cfg_tgt_e tgt_q, tgt_d;
  logic     is_max;
  logic     plain_rd, plain_wr;
  cfg_tgt_e sel_tgt;

  assign is_max   = &acc_addr;
  assign plain_rd = is_max && !acc_cre && !acc_write;
  assign plain_wr = is_max && !acc_cre && acc_write;
  assign sel_tgt  = data_decode(acc_data);

  assign sw_hit = acc && (state_q == S_ARM) && is_max && !acc_cre;
  assign sw_tgt = tgt_q;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    if (acc) begin
      state_d = S_IDLE;
      case (state_q)
        S_IDLE: if (plain_rd) state_d = S_RD1;
        S_RD1:  if (plain_rd) state_d = S_RD2;
        S_RD2: begin
          if (plain_wr && (sel_tgt != TGT_NONE)) begin
            state_d = S_ARM;
            tgt_d   = sel_tgt;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tgt_q   <= TGT_NONE;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

endmodule

// File: rtl/psram_cfg_field_reg.sv
module psram_cfg_field_reg
  import psram_cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] WMASK = 16'hFFFF,
  parameter logic [CFG_W-1:0] RST   = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] d,
  input  logic [CFG_W-1:0] keep,
  output logic [CFG_W-1:0] q
);

  logic [CFG_W-1:0] upd;
  assign upd = WMASK & ~keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST & WMASK;
    else if (we) q <= (q & ~upd) | (d & upd);
  end

endmodule

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
  import psram_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cfg_tgt_e         wr_tgt,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] bcr_q,
  output logic [CFG_W-1:0] rcr_q
);

  localparam int unsigned NREG = 2;
  localparam logic [NREG-1:0][CFG_W-1:0] REG_MASK = {BCR_WMASK, RCR_WMASK};
  localparam logic [NREG-1:0][CFG_W-1:0] REG_RST  = {BCR_RST, RCR_RST};
  localparam logic [NREG-1:0][1:0]       REG_ID   = {TGT_BCR, TGT_RCR};

  logic [NREG-1:0][CFG_W-1:0] q_all;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [CFG_W-1:0] keep;
    if (REG_ID[g] == TGT_BCR) begin : g_lat
      assign keep = lat_reserved(wr_data[LAT_LSB +: LAT_W]) ? LAT_MASK : '0;
    end else begin : g_plain
      assign keep = '0;
    end
    psram_cfg_field_reg #(
      .WMASK(REG_MASK[g]),
      .RST  (REG_RST[g])
    ) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en && (wr_tgt == cfg_tgt_e'(REG_ID[g]))),
      .d    (wr_data),
      .keep (keep),
      .q    (q_all[g])
    );
  end

  assign rcr_q = q_all[0];
  assign bcr_q = q_all[1];

endmodule

// File: rtl/psram_cfg_rsp.sv
module psram_cfg_rsp
  import psram_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [CFG_W-1:0] rd_data,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [CFG_W-1:0] rsp_data,
  output logic             free
);

  assign free = !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_en) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/psram_cfg_unit.sv
module psram_cfg_unit
  import psram_cfg_pkg::*;
#(
  parameter int unsigned      ADDR_W  = 22,
  parameter int unsigned      SEL_LSB = 18,
  parameter logic [15:0]      DEV_ID  = 16'h0A41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cre,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_data,
  output logic [15:0]       bcr_q,
  output logic [15:0]       rcr_q
);

  logic     fire;
  logic     pin_acc;
  cfg_tgt_e pin_tgt;
  logic     sw_hit;
  cfg_tgt_e sw_tgt;
  cfg_tgt_e tgt;
  logic     reg_acc;
  logic     wr_en, rd_en;
  logic [CFG_W-1:0] rd_mux;
  logic     free;

  assign fire    = req_valid && req_ready;
  assign pin_acc = fire && req_cre;
  assign pin_tgt = pin_decode(req_addr[SEL_LSB +: 2], req_write);

  psram_cfg_unlock #(.ADDR_W(ADDR_W)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (fire),
    .acc_write(req_write),
    .acc_cre  (req_cre),
    .acc_addr (req_addr),
    .acc_data (req_wdata),
    .sw_hit   (sw_hit),
    .sw_tgt   (sw_tgt)
  );

  assign tgt     = pin_acc ? pin_tgt : sw_tgt;
  assign reg_acc = pin_acc || sw_hit;
  assign wr_en   = reg_acc && req_write;
  assign rd_en   = reg_acc && !req_write;

  psram_cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_tgt (tgt),
    .wr_data(req_wdata),
    .bcr_q  (bcr_q),
    .rcr_q  (rcr_q)
  );

  always_comb begin
    case (tgt)
      TGT_RCR: rd_mux = rcr_q;
      TGT_BCR: rd_mux = bcr_q;
      TGT_DID: rd_mux = DEV_ID;
      default: rd_mux = '0;
    endcase
  end

  psram_cfg_rsp u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_data  (rd_mux),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .free     (free)
  );

  assign req_ready = free;

endmodule

// File: rtl/psram_cfg_chk.sv
module psram_cfg_chk
  import psram_cfg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        req_cre,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic [15:0] bcr_q,
  input logic [15:0] rcr_q
);

  // R4: non-writable bits stay zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bcr_q & ~BCR_WMASK) == '0) && ((rcr_q & ~RCR_WMASK) == '0));

  // R5: the latency field never takes a reserved code
  a_r5_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_reserved(bcr_q[LAT_LSB +: LAT_W]));

  // R9 / R7: registers move only after an accepted write
  a_r9_no_change_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(bcr_q) && $stable(rcr_q));

  // R3: a pin-path read yields a response next cycle
  a_r3_pin_read_responds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cre && !req_write) |=> rsp_valid);

  // R8: pending response blocks new requests
  a_r8_stall_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8: response held while not accepted
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

endmodule

bind psram_cfg_unit psram_cfg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_cre  (req_cre),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .bcr_q    (bcr_q),
  .rcr_q    (rcr_q)
);

// File: tb/test_psram_cfg_unit.sv
`timescale 1ns/1ps
module test_psram_cfg_unit;

  localparam int unsigned AW = 22;
  localparam logic [15:0] DEVID = 16'h0A41;
  localparam logic [AW-1:0] MAXA   = {AW{1'b1}};
  localparam logic [AW-1:0] A_RCR  = 22'h000000;
  localparam logic [AW-1:0] A_BCR  = 22'h080000;
  localparam logic [AW-1:0] A_DID  = 22'h040000;
  localparam logic [AW-1:0] A_NONE = 22'h0C0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_cre = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic rsp_ready = 1'b0;
  logic [15:0] rsp_data, bcr_q, rcr_q;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  logic hold = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  psram_cfg_unit #(.ADDR_W(AW), .SEL_LSB(18), .DEV_ID(DEVID)) i_psram_cfg_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cre(req_cre), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bcr_q(bcr_q), .rcr_q(rcr_q)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic acc(input logic w, input logic cre, input logic [AW-1:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = w; req_cre = cre; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_exp(input logic cre, input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(1'b0, cre, a, 16'h0);
  endtask

  task automatic unlock(input logic [15:0] sel);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b1, 1'b0, MAXA, sel);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      rsp_ready = hold ? 1'b0 : ((cyc % 3) != 1);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          vectors++;
          miscompares++;
          $display("FAIL R9 unexpected response actual=%h expected=none", rsp_data);
        end else begin
          check16(tag_q.pop_front(), rsp_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check16("R1 bcr reset", bcr_q, 16'h9C10);
    check16("R1 rcr reset", rcr_q, 16'h0010);
    check16("R1 ready after reset", {15'd0, req_ready}, 16'd1);
    check16("R1 no response after reset", {15'd0, rsp_valid}, 16'd0);

    // R3 pin reads
    rd_exp(1'b1, A_RCR, 16'h0010, "R3 pin read rcr");
    rd_exp(1'b1, A_BCR, 16'h9C10, "R3 pin read bcr");
    rd_exp(1'b1, A_DID, DEVID, "R3 pin read id");
    rd_exp(1'b1, A_NONE, 16'h0000, "R3 pin read code 11");

    // R4 / R5 masked write with reserved latency 7
    acc(1'b1, 1'b1, A_BCR, 16'hFFFF);
    check16("R4 R5 bcr all-ones write", bcr_q, 16'h9C30);
    acc(1'b1, 1'b1, A_BCR, 16'h0000);
    check16("R5 bcr latency 0 kept", bcr_q, 16'h1800);
    acc(1'b1, 1'b1, A_BCR, 16'h2010);
    check16("R2 bcr pin write", bcr_q, 16'h2010);
    acc(1'b1, 1'b1, A_RCR, 16'hFFFF);
    check16("R4 rcr masked write", rcr_q, 16'h0097);
    rd_exp(1'b1, A_RCR, 16'h0097, "R4 rcr readback");

    // R2 writes to id / unused code ignored
    acc(1'b1, 1'b1, A_DID, 16'h1234);
    acc(1'b1, 1'b1, A_NONE, 16'h5678);
    check16("R2 id write ignored bcr", bcr_q, 16'h2010);
    check16("R2 id write ignored rcr", rcr_q, 16'h0097);

    // R6 software path
    unlock(16'h0001);
    acc(1'b1, 1'b0, MAXA, 16'h8C20);
    check16("R6 R5 sw bcr write", bcr_q, 16'hA420);
    unlock(16'h0001);
    rd_exp(1'b0, MAXA, 16'hA420, "R6 sw bcr read");
    unlock(16'h0002);
    rd_exp(1'b0, MAXA, DEVID, "R6 sw id read");
    unlock(16'h0000);
    acc(1'b1, 1'b0, MAXA, 16'h0005);
    check16("R6 sw rcr write", rcr_q, 16'h0005);
    unlock(16'h0002);
    acc(1'b1, 1'b0, MAXA, 16'hFFFF);
    check16("R6 sw id write ignored", bcr_q, 16'hA420);
    check16("R6 sw id write ignored rcr", rcr_q, 16'h0005);

    // R7 broken sequences
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b0, 1'b0, 22'h000123, 16'h0);
    acc(1'b1, 1'b0, MAXA, 16'h0000);
    acc(1'b1, 1'b0, MAXA, 16'h0003);
    check16("R7 other address breaks", rcr_q, 16'h0005);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b1, 1'b0, MAXA, 16'h0001);
    acc(1'b1, 1'b0, MAXA, 16'h0000);
    check16("R7 third read breaks", bcr_q, 16'hA420);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b1, 1'b0, MAXA, 16'h0000);
    acc(1'b1, 1'b0, MAXA, 16'h0003);
    check16("R7 early write breaks", rcr_q, 16'h0005);
    unlock(16'h0005);
    acc(1'b1, 1'b0, MAXA, 16'h0003);
    check16("R7 bad selector breaks", rcr_q, 16'h0005);
    unlock(16'h0000);
    acc(1'b1, 1'b0, 22'h000100, 16'h0007);
    acc(1'b1, 1'b0, MAXA, 16'h0003);
    check16("R7 armed then other address", rcr_q, 16'h0005);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    acc(1'b0, 1'b0, MAXA, 16'h0);
    rd_exp(1'b1, A_RCR, 16'h0005, "R7 pin read mid sequence");
    acc(1'b1, 1'b0, MAXA, 16'h0001);
    acc(1'b1, 1'b0, MAXA, 16'h0000);
    check16("R7 pin cycle breaks", bcr_q, 16'hA420);

    // R9 plain array traffic
    acc(1'b0, 1'b0, 22'h000321, 16'h0);
    acc(1'b1, 1'b0, 22'h000321, 16'hFFFF);
    check16("R9 array write no effect bcr", bcr_q, 16'hA420);
    check16("R9 array write no effect rcr", rcr_q, 16'h0005);

    // R8 back-pressure
    #1 hold = 1'b1;
    @(negedge clk);
    rd_exp(1'b1, A_BCR, 16'hA420, "R8 held response data");
    check16("R8 response pending", {15'd0, rsp_valid}, 16'd1);
    check16("R8 ready low while pending", {15'd0, req_ready}, 16'd0);
    repeat (3) @(negedge clk);
    check16("R8 data held", rsp_data, 16'hA420);
    check16("R8 still stalled", {15'd0, req_ready}, 16'd0);
    #1 hold = 1'b0;

    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check16("R8 all responses delivered", 16'(exp_q.size()), 16'd0);

    summary();
    $finish;
  end

endmodule